// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that hangs off a shared timer count. In capture mode it watches one of four selectable sources: two external pins, a constant low and a constant high. On the chosen edge it copies the present count into its value register and raises its interrupt flag. Captures can fire on the cycle the edge is seen, or they can wait for the next timer tick. A sticky overrun bit records a capture that overwrote a value nobody had read yet.

In compare mode the same value register holds a reference. When the timer steps onto that reference, the channel emits a one-cycle equality pulse, raises the flag and stores the selected source level in a sampled-level bit. Software writes the register directly, and the write takes effect at once. Software can also set or clear the flag and clear the overrun bit. A read strobe tells the channel that the captured value has been consumed.

Switching the source between the two constants while both-edge capture is selected lets software force a capture at a known instant. All pins are plain level signals. The channel has no streaming data path, so no handshake applies.

Top module: `capcmp_channel`

## Requirements
- R1: Source select codes are 00 pin A, 01 pin B, 10 constant 0 and 11 constant 1. `level_o` shows the selected source at all times. Pin levels pass through a two-flop synchronizer, so a pin change appears on `level_o` after the second rising clock edge. A constant appears at once.
- R2: Edge select codes are 00 no capture, 01 rising only, 10 falling only and 11 both. An edge of a kind that is not selected leaves `value_o` unchanged.
- R3: With synchronization off, a selected edge of the source captures `count_i` into `value_o` and sets `flag_o` at the same clock edge that first sees the new level.
- R4: With synchronization on, a detected edge stays pending. The capture happens on the first cycle with `tick_i` high, and it stores the count of that cycle.
- R5: `ovf_o` sets when a capture occurs while the previous captured value is still unread. A `rd_strobe_i` in the same cycle as the capture counts as a read of the older value, so no overrun is recorded. `ovf_o` stays set until `ovf_clr_i`.
- R6: In compare mode, a cycle with `step_i` high and `count_i` equal to `value_o` does three things. It sets `flag_o`. It raises `equ_o` for exactly the next cycle. It latches `level_o` into `sampled_o`, which holds until the next match.
- R7: Without `step_i`, an equal count produces no equality pulse and does not set the flag.
- R8: `wr_en_i` loads `wr_data_i` into `value_o` at the next edge, and compare uses the new value from the following cycle on. A capture in the same cycle takes precedence over the write.
- R9: `flag_set_i` sets the flag and `flag_clr_i` clears it. A hardware set (capture or match) in the same cycle as a clear leaves the flag set.
- R10: After reset the value, flag, overrun, equality and sampled-level outputs are all 0.
- R11: Compare mode ignores source edges, and capture mode never produces an equality pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer clock enable for this cycle |
| step_i | input | 1 | Counter advanced to `count_i` this cycle by counting, not by a write |
| count_i | input | CNT_W | Current timer count |
| pin_a_i | input | 1 | External source A |
| pin_b_i | input | 1 | External source B |
| capture_mode_i | input | 1 | 1 capture mode, 0 compare mode |
| edge_sel_i | input | 2 | Capture edge select |
| src_sel_i | input | 2 | Source select |
| sync_en_i | input | 1 | Defer captures to the next tick |
| wr_en_i | input | 1 | Software write of the value register |
| wr_data_i | input | CNT_W | Write data |
| rd_strobe_i | input | 1 | Captured value has been read |
| flag_set_i | input | 1 | Software flag set |
| flag_clr_i | input | 1 | Software flag clear |
| ovf_clr_i | input | 1 | Software overrun clear |
| value_o | output | CNT_W | Capture/compare value register |
| flag_o | output | 1 | Interrupt flag |
| ovf_o | output | 1 | Sticky capture overrun |
| equ_o | output | 1 | One-cycle equality pulse |
| level_o | output | 1 | Live level of selected source |
| sampled_o | output | 1 | Source level latched at last match |

## Verification
The hardest situations to reach are those in which two events fall in the same cycle: a capture together with the read that clears the unread state, a match together with a software flag clear, and a synchronized capture that waits several cycles for a tick. The stimulus creates edges by switching the source between the two constants, which places each capture on an exact, known clock edge without going through the synchronizer. Reads, clears and ticks are then lined up on those same edges.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    SRC_PIN_A = 2'b00,
    SRC_PIN_B = 2'b01,
    SRC_LOW   = 2'b10,
    SRC_HIGH  = 2'b11
  } src_sel_e;
endpackage

// File: rtl/capcmp_input_stage.sv
module capcmp_input_stage
  import capcmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a_i,
  input  logic       pin_b_i,
  input  src_sel_e   src_sel_i,
  input  edge_mode_e edge_mode_i,
  output logic       level_o,
  output logic       edge_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_a_q, sync_b_q;
  logic prev_q;
  logic rise, fall;

  // synchronizer chains for the two pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a_q <= '0;
      sync_b_q <= '0;
    end else begin
      sync_a_q[0] <= pin_a_i;
      sync_b_q[0] <= pin_b_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_a_q[i] <= sync_a_q[i-1];
        sync_b_q[i] <= sync_b_q[i-1];
      end
    end
  end

  always_comb begin
    unique case (src_sel_i)
      SRC_PIN_A: level_o = sync_a_q[LAST];
      SRC_PIN_B: level_o = sync_b_q[LAST];
      SRC_LOW:   level_o = 1'b0;
      default:   level_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_o;
  end

  assign rise = level_o & ~prev_q;
  assign fall = ~level_o & prev_q;

  always_comb begin
    unique case (edge_mode_i)
      EDGE_NONE: edge_o = 1'b0;
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      default:   edge_o = rise | fall;
    endcase
  end

  assert_const_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i == SRC_LOW) |-> !level_o);
  assert_const_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i == SRC_HIGH) |-> level_o);
  assert_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i == EDGE_NONE) |-> !edge_o);
endmodule

// File: rtl/capcmp_capture_unit.sv
module capcmp_capture_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en_i,
  input  logic             sync_en_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_strobe_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] value_o,
  output logic             fire_o,
  output logic             ovf_o
);
  logic pend_q, unread_q;

  // deferred or immediate capture
  assign fire_o = cap_en_i & (sync_en_i ? (tick_i & (edge_i | pend_q)) : edge_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      unread_q <= 1'b0;
      ovf_o    <= 1'b0;
      value_o  <= '0;
    end else begin
      pend_q <= cap_en_i & sync_en_i & ~tick_i & (edge_i | pend_q);
      if (fire_o)       value_o <= count_i;
      else if (wr_en_i) value_o <= wr_data_i;
      if (fire_o)           unread_q <= 1'b1;
      else if (rd_strobe_i) unread_q <= 1'b0;
      if (fire_o && unread_q && !rd_strobe_i) ovf_o <= 1'b1;
      else if (ovf_clr_i)                     ovf_o <= 1'b0;
    end
  end

  assert_capture_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (value_o == $past(count_i)));
  assert_sync_waits_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && sync_en_i) |-> tick_i);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  assert_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !fire_o) |=> (value_o == $past(wr_data_i)));
endmodule

// File: rtl/capcmp_compare_unit.sv
module capcmp_compare_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic             level_i,
  output logic             hit_o,
  output logic             equ_o,
  output logic             sampled_o
);
  assign hit_o = cmp_en_i & step_i & (count_i == ref_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      equ_o     <= 1'b0;
      sampled_o <= 1'b0;
    end else begin
      equ_o <= hit_o;
      if (hit_o) sampled_o <= level_i;
    end
  end

  assert_equ_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    equ_o |-> $past(step_i));
  assert_no_equ_in_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    equ_o |-> $past(cmp_en_i));
  assert_sample_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (sampled_o == $past(level_i)));
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
  import capcmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             capture_mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [1:0]       src_sel_i,
  input  logic             sync_en_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_strobe_i,
  input  logic             flag_set_i,
  input  logic             flag_clr_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] value_o,
  output logic             flag_o,
  output logic             ovf_o,
  output logic             equ_o,
  output logic             level_o,
  output logic             sampled_o
);
  logic edge_hit, cap_fire, cmp_hit, hw_set;

  capcmp_input_stage #(.SYNC_STAGES(SYNC_STAGES)) in_stage_i (
    .clk(clk), .rst_n(rst_n), .pin_a_i(pin_a_i), .pin_b_i(pin_b_i),
    .src_sel_i(src_sel_e'(src_sel_i)), .edge_mode_i(edge_mode_e'(edge_sel_i)),
    .level_o(level_o), .edge_o(edge_hit)
  );

  capcmp_capture_unit #(.CNT_W(CNT_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .cap_en_i(capture_mode_i), .sync_en_i(sync_en_i),
    .tick_i(tick_i), .edge_i(edge_hit), .count_i(count_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_strobe_i(rd_strobe_i), .ovf_clr_i(ovf_clr_i),
    .value_o(value_o), .fire_o(cap_fire), .ovf_o(ovf_o)
  );

  capcmp_compare_unit #(.CNT_W(CNT_W)) cmp_i (
    .clk(clk), .rst_n(rst_n), .cmp_en_i(~capture_mode_i), .step_i(step_i),
    .count_i(count_i), .ref_i(value_o), .level_i(level_o),
    .hit_o(cmp_hit), .equ_o(equ_o), .sampled_o(sampled_o)
  );

  assign hw_set = cap_fire | cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= (flag_o & ~flag_clr_i) | flag_set_i | hw_set;
  end

  assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_o);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !flag_set_i && !hw_set) |=> !flag_o);
endmodule

// File: tb/capcmp_channel_tb_top.sv
`timescale 1ns/1ps
module capcmp_channel_tb_top;
  typedef enum {F_VAL, F_FLAG, F_OVF, F_EQU, F_LVL, F_SMP} field_e;
  typedef struct {
    string      req;
    field_e     fld;
    logic [15:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, step = 1'b0;
  logic [15:0] count = '0;
  logic pin_a = 1'b0, pin_b = 1'b0;
  logic cap_mode = 1'b0, sync_en = 1'b0;
  logic [1:0] edge_sel = 2'b00, src_sel = 2'b10;
  logic wr_en = 1'b0, rd = 1'b0, fset = 1'b0, fclr = 1'b0, oclr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] value;
  logic flag, ovf, equ, level, sampled;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  capcmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .step_i(step), .count_i(count),
    .pin_a_i(pin_a), .pin_b_i(pin_b), .capture_mode_i(cap_mode),
    .edge_sel_i(edge_sel), .src_sel_i(src_sel), .sync_en_i(sync_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_strobe_i(rd),
    .flag_set_i(fset), .flag_clr_i(fclr), .ovf_clr_i(oclr),
    .value_o(value), .flag_o(flag), .ovf_o(ovf), .equ_o(equ),
    .level_o(level), .sampled_o(sampled)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_out(string req, field_e fld, logic [15:0] exp);
    item_t it;
    it.req = req; it.fld = fld; it.exp = exp;
    sb_q.push_back(it);
  endtask

  function automatic logic [15:0] observe(field_e fld);
    case (fld)
      F_VAL:  return value;
      F_FLAG: return {15'd0, flag};
      F_OVF:  return {15'd0, ovf};
      F_EQU:  return {15'd0, equ};
      F_LVL:  return {15'd0, level};
      default: return {15'd0, sampled};
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      act = observe(it.fld);
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s %s: actual %h expected %h", it.req, it.fld.name(), act, it.exp);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R10 reset state
    expect_out("R10", F_VAL, 16'h0000);
    expect_out("R10", F_FLAG, 0);
    expect_out("R10", F_OVF, 0);
    expect_out("R10", F_EQU, 0);
    expect_out("R10", F_SMP, 0);
    cyc();

    // R1 source selection
    expect_out("R1", F_LVL, 0);
    cyc();
    src_sel = 2'b11; #1;
    expect_out("R1", F_LVL, 1);
    cyc();
    pin_a = 1'b1; src_sel = 2'b00;
    cyc();
    expect_out("R1", F_LVL, 0);
    cyc();
    expect_out("R1", F_LVL, 1);
    cyc();
    src_sel = 2'b01; #1;
    expect_out("R1", F_LVL, 0);
    cyc();

    // R3 immediate rising capture
    cap_mode = 1'b1; edge_sel = 2'b01; src_sel = 2'b10; count = 16'h1234; tick = 1'b1;
    cyc(); cyc();
    src_sel = 2'b11;
    cyc();
    expect_out("R3", F_VAL, 16'h1234);
    expect_out("R3", F_FLAG, 1);
    expect_out("R3", F_OVF, 0);
    rd = 1'b1; cyc(); rd = 1'b0;
    fclr = 1'b1; cyc(); fclr = 1'b0;
    expect_out("R9", F_FLAG, 0);

    // R2 edge select
    count = 16'h2222; src_sel = 2'b10;
    cyc();
    expect_out("R2", F_VAL, 16'h1234);
    expect_out("R2", F_FLAG, 0);
    edge_sel = 2'b10; count = 16'h3333; src_sel = 2'b11;
    cyc();
    expect_out("R2", F_VAL, 16'h1234);
    src_sel = 2'b10;
    cyc();
    expect_out("R2", F_VAL, 16'h3333);
    expect_out("R5", F_OVF, 0);
    rd = 1'b1; cyc(); rd = 1'b0;
    edge_sel = 2'b11; count = 16'h4444; src_sel = 2'b11;
    cyc();
    expect_out("R2", F_VAL, 16'h4444);
    count = 16'h5555; src_sel = 2'b10;
    cyc();
    expect_out("R2", F_VAL, 16'h5555);
    expect_out("R5", F_OVF, 1);
    edge_sel = 2'b00; count = 16'h6666; src_sel = 2'b11;
    cyc();
    expect_out("R2", F_VAL, 16'h5555);

    // R5 sticky overrun, read does not clear it
    rd = 1'b1; cyc(); rd = 1'b0;
    expect_out("R5", F_OVF, 1);
    oclr = 1'b1; cyc(); oclr = 1'b0;
    expect_out("R5", F_OVF, 0);
    edge_sel = 2'b11; count = 16'h7777; src_sel = 2'b10;
    cyc();
    count = 16'h8888; src_sel = 2'b11; rd = 1'b1;
    cyc();
    rd = 1'b0;
    expect_out("R5", F_VAL, 16'h8888);
    expect_out("R5", F_OVF, 0);

    // R4 synchronized capture waits for tick
    sync_en = 1'b1; tick = 1'b0; count = 16'h9999; src_sel = 2'b10;
    cyc();
    expect_out("R4", F_VAL, 16'h8888);
    cyc();
    expect_out("R4", F_VAL, 16'h8888);
    tick = 1'b1; count = 16'h0AAA;
    cyc();
    expect_out("R4", F_VAL, 16'h0AAA);
    expect_out("R5", F_OVF, 1);
    rd = 1'b1; oclr = 1'b1; fclr = 1'b1;
    cyc();
    rd = 1'b0; oclr = 1'b0; fclr = 1'b0; sync_en = 1'b0;

    // R11 compare mode ignores edges
    cap_mode = 1'b0; src_sel = 2'b11; count = 16'h0040; step = 1'b0;
    cyc();
    expect_out("R11", F_VAL, 16'h0AAA);
    expect_out("R11", F_FLAG, 0);

    // R8 direct write
    wr_en = 1'b1; wr_data = 16'h0050;
    cyc();
    wr_en = 1'b0;
    expect_out("R8", F_VAL, 16'h0050);

    // R6 compare match
    step = 1'b1; count = 16'h004F;
    cyc();
    expect_out("R6", F_EQU, 0);
    expect_out("R6", F_FLAG, 0);
    count = 16'h0050;
    cyc();
    expect_out("R6", F_EQU, 1);
    expect_out("R6", F_FLAG, 1);
    expect_out("R6", F_SMP, 1);
    count = 16'h0051;
    cyc();
    expect_out("R6", F_EQU, 0);
    expect_out("R6", F_SMP, 1);

    // R7 no step, no match
    fclr = 1'b1; step = 1'b0; cyc(); fclr = 1'b0;
    count = 16'h0050;
    cyc();
    expect_out("R7", F_EQU, 0);
    expect_out("R7", F_FLAG, 0);

    // R9 match beats clear; R6 latches low level
    src_sel = 2'b10; step = 1'b1; fclr = 1'b1;
    cyc();
    fclr = 1'b0; step = 1'b0;
    expect_out("R9", F_FLAG, 1);
    expect_out("R6", F_SMP, 0);
    fclr = 1'b1; cyc(); fclr = 1'b0;
    expect_out("R9", F_FLAG, 0);
    fset = 1'b1; cyc(); fset = 1'b0;
    expect_out("R9", F_FLAG, 1);

    // R11 capture mode gives no equality
    cap_mode = 1'b1; edge_sel = 2'b00; step = 1'b1; count = 16'h0050;
    cyc();
    expect_out("R11", F_EQU, 0);
    step = 1'b0;
    cyc(); cyc();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule